// File: doc/BRIEF.md
# Leveled Maskable Interrupt Controller

This block sits beside a small CPU core and decides which of several maskable interrupt sources is offered to it. Every source owns a pending flag and a three-bit level. A single-cycle request pulse on a source's input latches its pending flag. The CPU side supplies a global enable bit and a three-bit processor level. Both are written through the same register port that software uses to program source levels and to clear pending flags.

Each cycle the controller looks for sources that are eligible. Among them it picks the highest level, and on a tie the lowest source number. The result is presented to the CPU as a registered request line and a vector index. The CPU answers with a one-cycle acknowledge strobe. That strobe removes the pending flag of the source named by the index.

A combinational read port returns every stored element, so software can inspect the state it programmed.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, all pending flags read 0, all source levels read 000, the global enable reads 0, the processor level reads 000, and `irqReq` is 0.
- R2: A 1 on `reqPulse[i]` at a clock edge sets the pending flag of source i. The flag reads back as bit 0 of address 0x20+i.
- R3: A register write to address 0x20+i with `wrData[0]`=0 clears the pending flag of source i. A write with `wrData[0]`=1 leaves the flag unchanged and never raises `irqReq`.
- R4: The level of source i is written and read in bits 2:0 of address 0x10+i. Level 000 keeps the source from ever being offered. Levels 001 to 111 rank the source, with 111 the highest.
- R5: A source is eligible only when the global enable is 1, its pending flag is 1, and its level is strictly greater than the processor level. Consequently a processor level of 111 blocks every source.
- R6: While the global enable (address 0x00, bit 0) is 0, `irqReq` stays 0 whatever the pending flags and levels are.
- R7: Among eligible sources, the one with the highest level is indicated on `vecIdx`. Equal levels resolve to the lowest source number.
- R8: `irqReq` and `vecIdx` are registered. They reflect the stored state one clock edge after any change to pending flags, levels, enable or processor level (address 0x01, bits 2:0).
- R9: An `ack` strobe sampled while `irqReq` is 1 clears only the pending flag of the source named by `vecIdx`. An `ack` while `irqReq` is 0 changes nothing.
- R10: When a request pulse and an acknowledge for the same source meet at one edge, the pending flag of that source stays 1.
- R11: The global enable, the processor level, each level field and each pending flag are separate storage. A write to one address leaves all the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqPulse | input | NUM_SRC | Per-source request event, one cycle wide |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 6 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 6 | Register read address |
| rdData | output | 8 | Register read data, combinational |
| ack | input | 1 | CPU acknowledge strobe, one cycle wide |
| irqReq | output | 1 | Interrupt request to the CPU, registered |
| vecIdx | output | $clog2(NUM_SRC) | Index of the selected source, registered |

## Verification
Two functions can change a pending flag at the same edge. One is a new request pulse for a source. The other is that source being cleared, either by the CPU acknowledge or by a software clear write. The bench provokes the collision by raising the offered source's request line during its acknowledge cycle. It also pairs a software clear with a request pulse. In both cases it reads the flag back and expects it to remain set, while the flags of all other sources keep their values.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int LVL_W     = 3;
  localparam int IDX_MAX_W = 4;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int REGION_W  = ADDR_W - IDX_MAX_W;

  localparam logic [REGION_W-1:0] REGION_CTRL = 2'd0;
  localparam logic [REGION_W-1:0] REGION_LVL  = 2'd1;
  localparam logic [REGION_W-1:0] REGION_PEND = 2'd2;

  localparam logic [IDX_MAX_W-1:0] CTRL_EN_SLOT = 4'd0;
  localparam logic [IDX_MAX_W-1:0] CTRL_PL_SLOT = 4'd1;

  typedef logic [LVL_W-1:0] level_t;

  typedef struct packed {
    logic                 enWr;
    logic                 enVal;
    logic                 plWr;
    level_t               plVal;
    logic                 lvlWr;
    level_t               lvlVal;
    logic                 pendClr;
    logic [IDX_MAX_W-1:0] regIdx;
    logic                 ackClr;
    logic [IDX_MAX_W-1:0] ackIdx;
  } strobe_t;

endpackage

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ack,
  input  logic              irqReq,
  input  logic [IDX_W-1:0]  vecIdx,
  output strobe_t           strb
);

  logic [REGION_W-1:0]  region;
  logic [IDX_MAX_W-1:0] slot;
  logic                 slotValid;

  assign region    = wrAddr[ADDR_W-1:IDX_MAX_W];
  assign slot      = wrAddr[IDX_MAX_W-1:0];
  assign slotValid = ({1'b0, slot} < (IDX_MAX_W+1)'(NUM_SRC));

  always_comb begin
    strb         = '0;
    strb.enVal   = wrData[0];
    strb.plVal   = wrData[LVL_W-1:0];
    strb.lvlVal  = wrData[LVL_W-1:0];
    strb.regIdx  = slot;
    strb.ackIdx  = IDX_MAX_W'(vecIdx);
    // acknowledge is honoured only while a request is being offered
    strb.ackClr  = ack && irqReq;
    if (wrEn) begin
      unique case (region)
        REGION_CTRL: begin
          strb.enWr = (slot == CTRL_EN_SLOT);
          strb.plWr = (slot == CTRL_PL_SLOT);
        end
        REGION_LVL:  strb.lvlWr   = slotValid;
        // only a written zero clears; a written one is dropped here
        REGION_PEND: strb.pendClr = slotValid && !wrData[0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic [NUM_SRC-1:0]            reqPulse,
  input  logic [ADDR_W-1:0]             rdAddr,
  output logic [DATA_W-1:0]             rdData,
  output logic [NUM_SRC-1:0]            pendQ,
  output logic [NUM_SRC-1:0][LVL_W-1:0] lvlQ,
  output logic                          globalEn,
  output level_t                        procLvl,
  output logic                          irqReq,
  output logic [IDX_W-1:0]              vecIdx
);

  logic [NUM_SRC-1:0] elig;
  level_t             bestLvl;
  logic [IDX_W-1:0]   bestIdx;

  // CPU-side control storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
    end else if (strb.enWr) begin
      globalEn <= strb.enVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      procLvl <= '0;
    end else if (strb.plWr) begin
      procLvl <= strb.plVal;
    end
  end

  // per-source storage
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic lvlHit;
    logic swClr;
    logic cpuClr;

    assign lvlHit = strb.lvlWr   && (strb.regIdx == IDX_MAX_W'(i));
    assign swClr  = strb.pendClr && (strb.regIdx == IDX_MAX_W'(i));
    assign cpuClr = strb.ackClr  && (strb.ackIdx == IDX_MAX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lvlQ[i] <= '0;
      end else if (lvlHit) begin
        lvlQ[i] <= strb.lvlVal;
      end
    end

    // a new event dominates any clear at the same edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ[i] <= 1'b0;
      end else if (reqPulse[i]) begin
        pendQ[i] <= 1'b1;
      end else if (swClr || cpuClr) begin
        pendQ[i] <= 1'b0;
      end
    end

    assign elig[i] = globalEn && pendQ[i] && (lvlQ[i] > procLvl);
  end

  // priority pick: strictly greater keeps the lowest index on a tie
  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (lvlQ[i] > bestLvl)) begin
        bestLvl = lvlQ[i];
        bestIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq <= 1'b0;
      vecIdx <= '0;
    end else begin
      irqReq <= (bestLvl != '0);
      vecIdx <= bestIdx;
    end
  end

  // software read port
  logic [REGION_W-1:0]  rdRegion;
  logic [IDX_MAX_W-1:0] rdSlot;

  assign rdRegion = rdAddr[ADDR_W-1:IDX_MAX_W];
  assign rdSlot   = rdAddr[IDX_MAX_W-1:0];

  always_comb begin
    rdData = '0;
    unique case (rdRegion)
      REGION_CTRL: begin
        if (rdSlot == CTRL_EN_SLOT) rdData[0] = globalEn;
        if (rdSlot == CTRL_PL_SLOT) rdData[LVL_W-1:0] = procLvl;
      end
      REGION_LVL: begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (rdSlot == IDX_MAX_W'(i)) rdData[LVL_W-1:0] = lvlQ[i];
        end
      end
      REGION_PEND: begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (rdSlot == IDX_MAX_W'(i)) rdData[0] = pendQ[i];
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqPulse,
  input  logic               wrEn,
  input  logic [5:0]         wrAddr,
  input  logic [7:0]         wrData,
  input  logic [5:0]         rdAddr,
  output logic [7:0]         rdData,
  input  logic               ack,
  output logic               irqReq,
  output logic [IDX_W-1:0]   vecIdx
);

  strobe_t                       strb;
  logic [NUM_SRC-1:0]            pendQ;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvlQ;
  logic                          globalEn;
  level_t                        procLvl;

  irqc_control #(.NUM_SRC(NUM_SRC)) u_control (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .ack    (ack),
    .irqReq (irqReq),
    .vecIdx (vecIdx),
    .strb   (strb)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqPulse (reqPulse),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .pendQ    (pendQ),
    .lvlQ     (lvlQ),
    .globalEn (globalEn),
    .procLvl  (procLvl),
    .irqReq   (irqReq),
    .vecIdx   (vecIdx)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_SRC-1:0]      reqPulse,
  input logic                    ack,
  input logic                    irqReq,
  input logic [IDX_W-1:0]        vecIdx,
  input logic [NUM_SRC-1:0]      pendQ,
  input logic [NUM_SRC-1:0][2:0] lvlQ,
  input logic                    globalEn,
  input logic [2:0]              procLvl
);

  // one-cycle-old copy of the stored state that fed the output registers
  logic [NUM_SRC-1:0]      pendD;
  logic [NUM_SRC-1:0][2:0] lvlD;
  logic                    enD;
  logic [2:0]              plD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendD <= '0;
      lvlD  <= '0;
      enD   <= 1'b0;
      plD   <= '0;
    end else begin
      pendD <= pendQ;
      lvlD  <= lvlQ;
      enD   <= globalEn;
      plD   <= procLvl;
    end
  end

  assert_disabled_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> !irqReq);

  assert_top_level_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (procLvl == 3'd7) |=> !irqReq);

  assert_offer_is_eligible_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (enD && pendD[vecIdx] && (lvlD[vecIdx] > plD)));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    assert_set_only_by_event_R3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pendQ[i]) |-> $past(reqPulse[i]));

    assert_event_latched_R10: assert property (@(posedge clk) disable iff (!rstN)
      reqPulse[i] |=> pendQ[i]);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
      (ack && irqReq && (vecIdx == IDX_W'(i)) && !reqPulse[i]) |=> !pendQ[i]);
  end

endmodule

bind lvl_irq_ctrl irqc_checker #(.NUM_SRC(NUM_SRC)) u_irqcChecker (
  .clk      (clk),
  .rstN     (rstN),
  .reqPulse (reqPulse),
  .ack      (ack),
  .irqReq   (irqReq),
  .vecIdx   (vecIdx),
  .pendQ    (pendQ),
  .lvlQ     (lvlQ),
  .globalEn (globalEn),
  .procLvl  (procLvl)
);

// File: tb/test_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module test_lvl_irq_ctrl;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [N-1:0] reqPulse = '0;
  logic       wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [5:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       ack = 1'b0;
  logic       irqReq;
  logic [2:0] vecIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lvl_irq_ctrl #(.NUM_SRC(N)) i_lvl_irq_ctrl (
    .clk(clk), .rstN(rstN), .reqPulse(reqPulse), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .ack(ack),
    .irqReq(irqReq), .vecIdx(vecIdx)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic regWrite(logic [5:0] a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic regRead(logic [5:0] a, output int v);
    rdAddr = a;
    #1;
    v = int'(rdData);
  endtask

  task automatic pulse(logic [N-1:0] m);
    reqPulse = m;
    tick();
    reqPulse = '0;
  endtask

  task automatic readPend(output int m);
    int v;
    m = 0;
    for (int i = 0; i < N; i++) begin
      regRead(6'h20 + 6'(i), v);
      m |= (v & 1) << i;
    end
  endtask

  task automatic clearAll();
    for (int i = 0; i < N; i++) regWrite(6'h20 + 6'(i), 8'h00);
  endtask

  // expected winner from the rules: strict level test, highest level, lowest index on ties
  function automatic int pick(int en, int pend, int lv[N], int pl, output int idx);
    int best = 0;
    idx = 0;
    if (en == 0) return 0;
    for (int i = 0; i < N; i++) begin
      if (((pend >> i) & 1) == 1 && lv[i] > pl && lv[i] > best) begin
        best = lv[i];
        idx = i;
      end
    end
    return (best != 0) ? 1 : 0;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, m, exp_idx, exp_req, lfsr;
    int lv[N];

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();

    // R1 reset state
    check("R1 irqReq", int'(irqReq), 0);
    regRead(6'h00, v); check("R1 enable", v, 0);
    regRead(6'h01, v); check("R1 procLvl", v, 0);
    for (int i = 0; i < N; i++) begin
      regRead(6'h10 + 6'(i), v); check("R1 level", v, 0);
    end
    readPend(m); check("R1 pending", m, 0);

    // R3: writing 1 to a pending slot is ignored
    regWrite(6'h00, 8'h01);
    regWrite(6'h12, 8'h07);
    regWrite(6'h22, 8'h01);
    tick(); tick();
    readPend(m); check("R3 write one ignored", m, 0);
    check("R3 no request from write", int'(irqReq), 0);

    // R11 independence of storage
    regWrite(6'h01, 8'h03);
    regRead(6'h00, v); check("R11 enable kept", v, 1);
    regRead(6'h12, v); check("R11 level kept", v, 7);
    regRead(6'h13, v); check("R11 other level", v, 0);
    regWrite(6'h15, 8'h04);
    regRead(6'h01, v); check("R11 procLvl kept", v, 3);
    regRead(6'h12, v); check("R11 level2 kept", v, 7);
    pulse(8'h04);
    regWrite(6'h16, 8'h02);
    readPend(m); check("R11 pend kept", m, 32'h04);
    regWrite(6'h00, 8'h00);
    regRead(6'h01, v); check("R11 procLvl after en", v, 3);
    readPend(m); check("R11 pend after en", m, 32'h04);

    // R6 enable gates, R8 one-cycle latency after enable write
    tick(); tick();
    check("R6 disabled no request", int'(irqReq), 0);
    regWrite(6'h00, 8'h01);
    check("R8 not yet after enable", int'(irqReq), 0);
    tick();
    check("R8 request after enable", int'(irqReq), 1);
    check("R8 vec after enable", int'(vecIdx), 2);
    regWrite(6'h01, 8'h07);
    tick();
    check("R5 level seven blocks", int'(irqReq), 0);
    clearAll();
    for (int i = 0; i < N; i++) regWrite(6'h10 + 6'(i), 8'h00);

    // R2 R4 R5 R8 sweep of every source, level and processor level
    for (int s = 0; s < N; s++) begin
      for (int l = 0; l < 8; l++) begin
        regWrite(6'h10 + 6'(s), 8'(l));
        for (int p = 0; p < 8; p++) begin
          regWrite(6'h01, 8'(p));
          tick();
          pulse(8'(1 << s));
          regRead(6'h20 + 6'(s), v);
          check("R2 pending set", v, 1);
          check("R8 output not yet", int'(irqReq), 0);
          tick();
          check("R5 strict compare", int'(irqReq), (l > p) ? 1 : 0);
          if (l > p) check("R4 vector", int'(vecIdx), s);
          regWrite(6'h20 + 6'(s), 8'h00);
          tick();
          check("R3 cleared by zero", int'(irqReq), 0);
        end
      end
      regWrite(6'h10 + 6'(s), 8'h00);
    end

    // R7 R9 random patterns with priority and acknowledge
    lfsr = 32'h1ACE;
    for (int it = 0; it < 300; it++) begin
      int mask, pl;
      for (int i = 0; i < N; i++) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
        lv[i] = (it % 3 == 0) ? (lfsr & 1) * 5 + 1 : lfsr & 7;
        regWrite(6'h10 + 6'(i), 8'(lv[i]));
      end
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      mask = lfsr & 8'hFF;
      pl = (lfsr >> 8) & 3;
      regWrite(6'h01, 8'(pl));
      pulse(8'(mask));
      tick();
      exp_req = pick(1, mask, lv, pl, exp_idx);
      check("R7 request", int'(irqReq), exp_req);
      if (exp_req == 1) begin
        check("R7 winner", int'(vecIdx), exp_idx);
        ack = 1'b1;
        tick();
        ack = 1'b0;
        readPend(m);
        check("R9 ack clears winner only", m, mask & ~(1 << exp_idx));
        tick();
        exp_req = pick(1, m, lv, pl, exp_idx);
        check("R9 next offer", int'(irqReq), exp_req);
      end
      clearAll();
    end

    // R9 ack ignored when no request offered
    regWrite(6'h00, 8'h00);
    regWrite(6'h13, 8'h06);
    regWrite(6'h01, 8'h00);
    pulse(8'h08);
    tick();
    ack = 1'b1; tick(); ack = 1'b0;
    readPend(m); check("R9 idle ack ignored", m, 32'h08);

    // R10 request and acknowledge for the same source at one edge
    regWrite(6'h00, 8'h01);
    tick();
    check("R10 offered", int'(irqReq), 1);
    check("R10 offered vec", int'(vecIdx), 3);
    ack = 1'b1; reqPulse = 8'h08;
    tick();
    ack = 1'b0; reqPulse = '0;
    readPend(m); check("R10 pending survives", m, 32'h08);

    // R10 software clear colliding with a new event
    wrEn = 1'b1; wrAddr = 6'h23; wrData = 8'h00; reqPulse = 8'h08;
    tick();
    wrEn = 1'b0; reqPulse = '0;
    readPend(m); check("R10 event beats clear", m, 32'h08);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule